// File: doc/BRIEF.md
# CPU Bus Access Request Generator

This block sits between a processor core and a 16-bit big-endian external bus. The core hands it one memory access at a time: a privilege flag, an access kind, a size, an address and, for stores, the data to write. The block turns that request into bus-cycle attributes. These are a 3-bit address-space code, a 5-bit status word that describes the cycle, upper and lower byte-lane strobes, a read/write line and the cycle address. It then holds each cycle open until the bus acknowledges it.

A 32-bit access becomes two consecutive 16-bit cycles, with the more significant half transferred first. A 16-bit or 32-bit access at an odd address is refused. In that case the block signals an error and never starts a bus cycle. Single-byte accesses may use any address and are steered onto one byte lane. Read data from the bus is assembled in big-endian order and returned to the core with a one-cycle completion pulse.

The access kind is encoded as 0 for instruction fetch, 1 for data read, 2 for data write and 3 for a processor-space read. The size is encoded as 0 for byte, 1 for 16-bit word and 2 for 32-bit long; the value 3 is treated as word. An instruction fetch of byte size is treated as a word fetch.

Top module: `busReqGen`

## Requirements
- R1: The address-space code on `busFc` is 2 for a user instruction fetch and 6 for a supervisor instruction fetch. It is 1 for a user data read or write and 5 for a supervisor one. It is 7 for a processor-space read, whatever the privilege flag.
- R2: `busStatus` holds the address-space code in bits 2:0. Bit 3 is 0 for an instruction fetch and 1 for any other kind. Bit 4 is 1 for a read and 0 for a write, and `busRw` equals bit 4.
- R3: A word or long request whose address bit 0 is 1 is refused. `respError` is high for exactly one cycle, in the cycle after acceptance. `busAs` stays low, so no bus cycle starts.
- R4: A byte access at any address runs one cycle. An even address drives `busUds` only (lane D15:8), and an odd address drives `busLds` only (lane D7:0). Word and long cycles drive both strobes.
- R5: A long access runs two cycles. The first is at the request address and the second at that address plus 2.
- R6: Read data is returned big-endian on `respRdata`. A long read returns the first cycle's 16 bits in bits 31:16 and the second cycle's in bits 15:0. A word read is zero-extended. A byte read is taken from its lane, zero-extended, and placed in bits 7:0.
- R7: Write data is placed on `busWdata` as follows. A byte write puts data bits 7:0 on both lanes. A word write sends data bits 15:0. A long write sends bits 31:16 in the first cycle and bits 15:0 in the second.
- R8: `reqReady` is high only when no access is in progress. A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. `respDone` is a one-cycle pulse in the cycle after the final acknowledged bus cycle, and it is never high together with `respError`.
- R9: Each bus cycle stays active until `busAck` is sampled high. While it waits, `busAddr`, `busStatus`, `busFc` and `busWdata` hold their values.
- R10: After reset, `busFc` is 0, `busStatus` is 5'b10000 (read, code 0), `busAddr` is 0, `busAs` is low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core request valid |
| reqReady | output | 1 | Block can accept a request |
| reqSuper | input | 1 | Supervisor privilege flag |
| reqKind | input | 2 | 0 fetch, 1 data read, 2 data write, 3 processor-space read |
| reqSize | input | 2 | 0 byte, 1 word, 2 long (3 treated as word) |
| reqAddr | input | ADDR_W | Request byte address |
| reqWdata | input | 32 | Store data, right-aligned |
| respDone | output | 1 | One-cycle completion pulse |
| respError | output | 1 | One-cycle misalignment rejection pulse |
| respRdata | output | 32 | Assembled read data, valid with respDone |
| busAs | output | 1 | Bus cycle active |
| busRw | output | 1 | 1 read, 0 write |
| busFc | output | 3 | Address-space code |
| busStatus | output | 5 | Packed cycle status word |
| busUds | output | 1 | Upper byte lane strobe (D15:8) |
| busLds | output | 1 | Lower byte lane strobe (D7:0) |
| busAddr | output | ADDR_W | Cycle address |
| busWdata | output | 16 | Bus write data |
| busRdata | input | 16 | Bus read data, sampled with busAck |
| busAck | input | 1 | Bus cycle acknowledge |

## Verification
The assertions assume that `busAck` is only raised while `busAs` is high, and that `reqSize` and `reqKind` carry one of the listed encodings. The stability checks also rely on nothing but the block's own registers driving the cycle attributes while the cycle waits. The bench's bus responder only raises `busAck` after it has seen an active cycle, and it drops it again at the next sampling point. The responder inserts 0 to 2 random wait cycles per cycle. Random requests draw their address from a small window with both parities of bit 0, so that refusals, odd bytes and long splits all occur.

// File: rtl/busreq_pkg.sv
package busreq_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_CPU   = 2'd3
  } accKind_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_t;

  localparam logic [2:0] FC_USER_DATA  = 3'd1;
  localparam logic [2:0] FC_USER_PROG  = 3'd2;
  localparam logic [2:0] FC_SUPER_DATA = 3'd5;
  localparam logic [2:0] FC_SUPER_PROG = 3'd6;
  localparam logic [2:0] FC_CPU_SPACE  = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new request
    logic step;     // advance to second word of a long access
    logic capture;  // take bus read data
    logic active;   // a bus cycle is in progress
  } ctrlStrobes_t;

  function automatic accSize_t effSize(input accKind_t kind, input accSize_t size);
    if (size == SZ_RSVD) return SZ_WORD;
    if (kind == KIND_FETCH && size == SZ_BYTE) return SZ_WORD;
    return size;
  endfunction

  function automatic logic [2:0] spaceCode(input accKind_t kind, input logic sup);
    unique case (kind)
      KIND_FETCH: return sup ? FC_SUPER_PROG : FC_USER_PROG;
      KIND_CPU:   return FC_CPU_SPACE;
      default:    return sup ? FC_SUPER_DATA : FC_USER_DATA;
    endcase
  endfunction

endpackage

// File: rtl/busReqPath.sv
module busReqPath import busreq_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              reqSuper,
  input  logic [1:0]        reqKind,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [15:0]       busRdata,
  input  logic              busAck,
  output logic              misalign,
  output logic              isLong,
  output logic [31:0]       respRdata,
  output logic              busRw,
  output logic [2:0]        busFc,
  output logic [4:0]        busStatus,
  output logic              busUds,
  output logic              busLds,
  output logic [ADDR_W-1:0] busAddr,
  output logic [15:0]       busWdata
);

  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

  accKind_t  kindIn;
  accSize_t  sizeIn;
  accSize_t  sizeQ;
  logic [2:0]        fcQ;
  logic              readQ;
  logic              notInsnQ;
  logic              secondQ;
  logic [ADDR_W-1:0] addrQ;
  logic [31:0]       wdataQ;
  logic [31:0]       rdataQ;

  assign kindIn   = accKind_t'(reqKind);
  assign sizeIn   = effSize(kindIn, accSize_t'(reqSize));
  assign misalign = (sizeIn != SZ_BYTE) && reqAddr[0];
  assign isLong   = (sizeQ == SZ_LONG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fcQ      <= 3'd0;
      readQ    <= 1'b1;
      notInsnQ <= 1'b0;
      sizeQ    <= SZ_WORD;
      addrQ    <= '0;
      wdataQ   <= '0;
      rdataQ   <= '0;
      secondQ  <= 1'b0;
    end else begin
      if (strobes.load) begin
        fcQ      <= spaceCode(kindIn, reqSuper);
        readQ    <= (kindIn != KIND_WRITE);
        notInsnQ <= (kindIn != KIND_FETCH);
        sizeQ    <= sizeIn;
        addrQ    <= reqAddr;
        wdataQ   <= reqWdata;
        rdataQ   <= '0;
        secondQ  <= 1'b0;
      end else if (strobes.capture) begin
        unique case (sizeQ)
          SZ_BYTE: rdataQ <= {24'd0, addrQ[0] ? busRdata[7:0] : busRdata[15:8]};
          SZ_LONG: begin
            if (secondQ) rdataQ[15:0]  <= busRdata;
            else         rdataQ[31:16] <= busRdata;
          end
          default: rdataQ <= {16'd0, busRdata};
        endcase
        if (strobes.step) begin
          addrQ   <= addrQ + WORD_STEP;
          secondQ <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    unique case (sizeQ)
      SZ_BYTE: busWdata = {wdataQ[7:0], wdataQ[7:0]};
      SZ_LONG: busWdata = secondQ ? wdataQ[15:0] : wdataQ[31:16];
      default: busWdata = wdataQ[15:0];
    endcase
  end

  assign busUds    = strobes.active && ((sizeQ != SZ_BYTE) || !addrQ[0]);
  assign busLds    = strobes.active && ((sizeQ != SZ_BYTE) || addrQ[0]);
  assign busAddr   = addrQ;
  assign busFc     = fcQ;
  assign busRw     = readQ;
  assign busStatus = {readQ, notInsnQ, fcQ};
  assign respRdata = rdataQ;

  // R9: attributes hold while a cycle waits for acknowledge
  a_r9_attrs_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.active && !busAck) |=> ($stable(busAddr) && $stable(busStatus) && $stable(busWdata)));

  // R5: second half of a long access sits two bytes above the first
  a_r5_second_addr: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (busAddr == $past(busAddr) + WORD_STEP));

  // R4: a byte cycle uses exactly one lane
  a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.active && sizeQ == SZ_BYTE) |-> $onehot({busUds, busLds}));

  // R4: no lane strobes outside a cycle
  a_r4_idle_no_lane: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.active |-> !(busUds || busLds));

endmodule

// File: rtl/busReqCtrl.sv
module busReqCtrl import busreq_pkg::*; (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         misalign,
  input  logic         isLong,
  input  logic         busAck,
  output logic         reqReady,
  output logic         respDone,
  output logic         respError,
  output ctrlStrobes_t strobes
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } ctrlState_t;

  ctrlState_t state;
  logic accept;

  assign accept   = reqValid && (state == ST_IDLE);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strobes.load    = accept;
    strobes.active  = (state != ST_IDLE);
    strobes.capture = strobes.active && busAck;
    strobes.step    = (state == ST_HIGH) && busAck && isLong;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      respDone  <= 1'b0;
      respError <= 1'b0;
    end else begin
      respDone  <= 1'b0;
      respError <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (misalign) respError <= 1'b1;
            else          state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (busAck) begin
            if (isLong) state <= ST_LOW;
            else begin
              state    <= ST_IDLE;
              respDone <= 1'b1;
            end
          end
        end
        ST_LOW: begin
          if (busAck) begin
            state    <= ST_IDLE;
            respDone <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a refused request never opens a bus cycle
  a_r3_no_cycle_on_reject: assert property (@(posedge clk) disable iff (!rstN)
    (accept && misalign) |=> (!strobes.active && respError));

  // R8: completion and rejection are exclusive
  a_r8_done_err_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(respDone && respError));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone);

  // R9: a waiting cycle stays in the same phase
  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !busAck) |=> (state == $past(state)));

endmodule

// File: rtl/busReqGen.sv
module busReqGen import busreq_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqSuper,
  input  logic [1:0]        reqKind,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              respDone,
  output logic              respError,
  output logic [31:0]       respRdata,
  output logic              busAs,
  output logic              busRw,
  output logic [2:0]        busFc,
  output logic [4:0]        busStatus,
  output logic              busUds,
  output logic              busLds,
  output logic [ADDR_W-1:0] busAddr,
  output logic [15:0]       busWdata,
  input  logic [15:0]       busRdata,
  input  logic              busAck
);

  ctrlStrobes_t strobes;
  logic misalign;
  logic isLong;

  busReqCtrl ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .misalign  (misalign),
    .isLong    (isLong),
    .busAck    (busAck),
    .reqReady  (reqReady),
    .respDone  (respDone),
    .respError (respError),
    .strobes   (strobes)
  );

  busReqPath #(.ADDR_W(ADDR_W)) path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqSuper  (reqSuper),
    .reqKind   (reqKind),
    .reqSize   (reqSize),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .busRdata  (busRdata),
    .busAck    (busAck),
    .misalign  (misalign),
    .isLong    (isLong),
    .respRdata (respRdata),
    .busRw     (busRw),
    .busFc     (busFc),
    .busStatus (busStatus),
    .busUds    (busUds),
    .busLds    (busLds),
    .busAddr   (busAddr),
    .busWdata  (busWdata)
  );

  assign busAs = strobes.active;

  // R2: read/write line agrees with the status word
  a_r2_rw_matches_status: assert property (@(posedge clk) disable iff (!rstN)
    busAs |-> (busRw == busStatus[4]));

endmodule

// File: tb/busReqGen_test.sv
`timescale 1ns/1ps
module busReqGen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqSuper = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [1:0]  reqSize = 2'd1;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        respDone, respError;
  logic [31:0] respRdata;
  logic        busAs, busRw, busUds, busLds;
  logic [2:0]  busFc;
  logic [4:0]  busStatus;
  logic [31:0] busAddr;
  logic [15:0] busWdata;
  logic [15:0] busRdata = '0;
  logic        busAck = 1'b0;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  busReqGen uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqSuper(reqSuper), .reqKind(reqKind), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .respDone(respDone),
    .respError(respError), .respRdata(respRdata), .busAs(busAs),
    .busRw(busRw), .busFc(busFc), .busStatus(busStatus), .busUds(busUds),
    .busLds(busLds), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busAck(busAck)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [15:0] memWord(input logic [31:0] a);
    return {memByte({a[31:1], 1'b0}), memByte({a[31:1], 1'b1})};
  endfunction

  function automatic logic [2:0] expFc(input logic [1:0] kind, input logic sup);
    if (kind == 2'd0) return sup ? 3'd6 : 3'd2;
    if (kind == 2'd3) return 3'd7;
    return sup ? 3'd5 : 3'd1;
  endfunction

  function automatic logic [1:0] expSize(input logic [1:0] kind, input logic [1:0] size);
    if (size == 2'd3) return 2'd1;
    if (kind == 2'd0 && size == 2'd0) return 2'd1;
    return size;
  endfunction

  task automatic runAccess(input logic [1:0] kind, input logic sup, input logic [1:0] size,
                           input logic [31:0] addr, input logic [31:0] wdata);
    logic [1:0]  sz;
    logic        bad;
    logic        isRd;
    logic [4:0]  st;
    logic [31:0] cycAddr;
    logic [15:0] expW;
    logic [31:0] expR;
    int delay;
    int cyc;
    int guard;
    bit sawDone;
    bit sawErr;
    sz = expSize(kind, size);
    bad = (sz != 2'd0) && addr[0];
    isRd = (kind != 2'd2);
    st = {isRd, (kind != 2'd0), expFc(kind, sup)};
    @(negedge clk);
    chk(reqReady == 1'b1, "R8 ready before request", {31'd0, reqReady}, 32'd1);
    reqValid = 1'b1; reqKind = kind; reqSuper = sup; reqSize = size;
    reqAddr = addr; reqWdata = wdata;
    @(negedge clk);
    reqValid = 1'b0;
    delay = -1; cyc = 0; guard = 0; sawDone = 0; sawErr = 0; cycAddr = '0;
    while (guard < 100) begin
      guard++;
      if (busAck) begin busAck = 1'b0; delay = -1; end
      if (respDone || respError) begin
        sawDone = respDone; sawErr = respError;
        break;
      end
      if (busAs) begin
        if (delay < 0) begin
          cycAddr = (cyc == 0) ? addr : addr + 32'd2;
          chk(busAddr == cycAddr, "R5 cycle address", busAddr, cycAddr);
          chk(busFc == expFc(kind, sup), "R1 space code", {29'd0, busFc}, {29'd0, expFc(kind, sup)});
          chk(busStatus == st, "R2 status word", {27'd0, busStatus}, {27'd0, st});
          chk(busRw == isRd, "R2 rw line", {31'd0, busRw}, {31'd0, isRd});
          if (sz == 2'd0)
            chk({busUds, busLds} == {!addr[0], addr[0]}, "R4 byte lane",
                {30'd0, busUds, busLds}, {30'd0, !addr[0], addr[0]});
          else
            chk(busUds && busLds, "R4 both lanes", {30'd0, busUds, busLds}, 32'd3);
          if (!isRd) begin
            if (sz == 2'd0)      expW = {wdata[7:0], wdata[7:0]};
            else if (sz == 2'd2) expW = (cyc == 0) ? wdata[31:16] : wdata[15:0];
            else                 expW = wdata[15:0];
            chk(busWdata == expW, "R7 write lanes", {16'd0, busWdata}, {16'd0, expW});
          end
          cyc++;
          delay = int'($urandom % 3);
        end else begin
          chk(busAddr == cycAddr, "R9 address held", busAddr, cycAddr);
          chk(busStatus == st, "R9 status held", {27'd0, busStatus}, {27'd0, st});
        end
        if (delay == 0) begin
          busAck = 1'b1;
          busRdata = memWord(busAddr);
        end else delay--;
      end
      @(negedge clk);
    end
    if (bad) begin
      chk(sawErr && !sawDone, "R3 error pulse", {30'd0, sawErr, sawDone}, 32'd2);
      chk(cyc == 0, "R3 no bus cycle", cyc, 0);
    end else begin
      chk(sawDone && !sawErr, "R8 done pulse", {30'd0, sawDone, sawErr}, 32'd2);
      chk(cyc == ((sz == 2'd2) ? 2 : 1), "R5 cycle count", cyc, (sz == 2'd2) ? 2 : 1);
      if (isRd) begin
        if (sz == 2'd0)      expR = {24'd0, memByte(addr)};
        else if (sz == 2'd2) expR = {memWord(addr), memWord(addr + 32'd2)};
        else                 expR = {16'd0, memWord(addr)};
        chk(respRdata == expR, "R6 read data", respRdata, expR);
      end
    end
    @(negedge clk);
    chk(!respDone && !respError, "R8 single-cycle response", {30'd0, respDone, respError}, 32'd0);
    chk(reqReady, "R8 ready after response", {31'd0, reqReady}, 32'd1);
  endtask

  initial begin
    int n;
    n = 0;
    while (n < 100000) begin
      @(posedge clk);
      n++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", n, 100000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(busFc == 3'd0, "R10 fc after reset", {29'd0, busFc}, 32'd0);
    chk(busStatus == 5'b10000, "R10 status after reset", {27'd0, busStatus}, 32'h10);
    chk(busAddr == 32'd0, "R10 address after reset", busAddr, 32'd0);
    chk(!busAs && reqReady, "R10 idle after reset", {30'd0, busAs, reqReady}, 32'd1);

    // directed corner cases
    runAccess(2'd1, 1'b0, 2'd2, 32'h0000_0103, 32'h0);          // R3 odd long read
    runAccess(2'd2, 1'b1, 2'd1, 32'h0000_0011, 32'h0000_BEEF);  // R3 odd word write
    runAccess(2'd0, 1'b1, 2'd1, 32'h0000_0021, 32'h0);          // R3 odd fetch
    runAccess(2'd1, 1'b0, 2'd0, 32'h0000_0045, 32'h0);          // R4 odd byte read
    runAccess(2'd2, 1'b1, 2'd0, 32'h0000_0046, 32'h0000_00C3);  // R4/R7 even byte write
    runAccess(2'd1, 1'b1, 2'd2, 32'h0000_0200, 32'h0);          // R5/R6 long read
    runAccess(2'd2, 1'b0, 2'd2, 32'h0000_0302, 32'h1234_5678);  // R7 long write
    runAccess(2'd0, 1'b0, 2'd1, 32'h0000_0400, 32'h0);          // R1 user fetch
    runAccess(2'd0, 1'b1, 2'd0, 32'h0000_0402, 32'h0);          // R1 byte fetch as word
    runAccess(2'd3, 1'b0, 2'd1, 32'h0000_FFF8, 32'h0);          // R1 processor space
    runAccess(2'd1, 1'b0, 2'd3, 32'h0000_0010, 32'h0);          // reserved size as word

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [1:0]  k;
      logic [1:0]  s;
      logic [31:0] a;
      logic [31:0] w;
      k = 2'($urandom % 4);
      s = 2'($urandom % 3);
      a = 32'($urandom % 1024);
      w = $urandom;
      runAccess(k, 1'($urandom % 2), s, a, w);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule